// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block tracks the lines held by one level of a set-associative cache. It has no data storage. For every way of every set it keeps an occupancy bit, the full line address, a permission state and a lock-owner context. A controller issues one command per cycle. A command can look up a line, check whether a line could be placed, place it, remove it, name a replacement victim, promote a line to most recently used, set, clear or test a lock, change a permission, or read back one way of a set. Each set also keeps its own least-recently-used order.

Every command is answered on a registered response port one cycle after it is accepted. The state change caused by that command happens on the same clock edge. A command that would break a directory rule is refused: the response reports an error and the stored state stays as it was. Addresses are assumed to be line aligned. The full address is stored and compared, so no line offset is stripped.

Top module: `tag_directory`

## Requirements
- R1: The set is selected by the `$clog2(SETS)`-bit field of `req_addr` that starts at bit `IDX_LO` (default bits [3:2]). Commands act only on that set, and lines in other sets are not affected.
- R2: Lookup (cmd 1) hits only when an occupied way holds exactly `req_addr` and its permission is not NotPresent. A hit returns ok=1 with the way, the address and the permission. A miss returns ok=1'b0 and zeros.
- R3: Availability (cmd 2) returns ok=1 when some way of the set is empty, some way has permission NotPresent, or some occupied way already holds `req_addr`, in any permission.
- R4: Allocate (cmd 3) chooses the lowest-numbered way that is empty or NotPresent. It stores the address, sets the permission to Invalid (1) and sets the lock owner to all ones, which means no owner. The response is ok=1 with the way. If the line already hits, or no way is free, the response is an error.
- R5: A successful allocate makes the chosen way most recently used only when `req_touch` is 1. Otherwise the replacement order is left unchanged.
- R6: Deallocate (cmd 4) of a hitting line empties its way, so later lookups miss and the way counts as free. Deallocate of a line that does not hit is an error.
- R7: Probe (cmd 5) is legal only when availability would return 0. It then returns ok=1 with the least recently used way of the set and the address that way holds. Otherwise it is an error.
- R8: Each set keeps a strict LRU order. After reset, way 0 is the most recently used and way WAYS-1 is the least. Touch (cmd 6) on a hitting line makes it most recently used and returns ok=1 with the way. Touch on a miss returns ok=0, raises no error and changes nothing.
- R9: Set lock (cmd 7) stores `req_ctx` as the owner of a hitting line, and clear lock (cmd 8) writes all ones. Test lock (cmd 9) returns ok=1 only when the stored owner equals `req_ctx`. All three are errors on a line that does not hit.
- R10: Permission codes are NotPresent=0, Invalid=1, Read_Only=2, Read_Write=3 and Busy=4. Set permission (cmd 10) writes `req_perm` into a hitting line and is an error otherwise. Way info (cmd 11) reports way `req_way` of the set. It returns ok=occupied, the address (0 if empty), the permission (0 if empty), rsp_invalid=(permission is Invalid) and rsp_not_busy=(permission is not Busy).
- R11: A command that responds with rsp_err=1 has rsp_ok=0, zero fields, and leaves every way's stored state unchanged.
- R12: The response appears in the cycle after the request. rsp_valid follows req_valid. With no request, or with cmd 0 or an unused code, all other response fields are 0. After reset every way is empty with NotPresent and no owner, and the response is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present this cycle |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Line address |
| req_ctx | input | CTX_W | Requester context for lock commands |
| req_touch | input | 1 | Allocate also promotes the way to most recently used |
| req_perm | input | 3 | Permission written by set permission |
| req_way | input | $clog2(WAYS) | Way selected by way info |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Command result (hit, available, success, lock match) |
| rsp_err | output | 1 | Command refused |
| rsp_way | output | $clog2(WAYS) | Way concerned |
| rsp_addr | output | ADDR_W | Stored address returned |
| rsp_perm | output | 3 | Stored permission returned |
| rsp_invalid | output | 1 | Reported way is Invalid |
| rsp_not_busy | output | 1 | Reported way is not Busy |

## Verification
The bench targets the cases where permission changes the meaning of a tag match. One case is a line set to NotPresent that still holds its address: it must miss on lookup, count as free, and be the slot a later allocate reuses. A design that tested only occupancy would report a false hit, or it would put the line in a higher way. A second group of cases covers the LRU order after allocations with and without touch and after touches. A wrong promotion shows up as the wrong probe victim. The last group covers the lock reset done by allocate and the refusals of illegal allocates and probes. A design that reused a stale owner, or that partly updated state on a refused command, fails the next test-lock or lookup that the model predicts.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  localparam int PERM_W = 3;

  typedef enum logic [PERM_W-1:0] {
    PERM_NOT_PRESENT = 3'd0,
    PERM_INVALID     = 3'd1,
    PERM_READ_ONLY   = 3'd2,
    PERM_READ_WRITE  = 3'd3,
    PERM_BUSY        = 3'd4
  } perm_e;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_LOOKUP   = 4'd1,
    CMD_AVAIL    = 4'd2,
    CMD_ALLOC    = 4'd3,
    CMD_DEALLOC  = 4'd4,
    CMD_PROBE    = 4'd5,
    CMD_TOUCH    = 4'd6,
    CMD_SETLOCK  = 4'd7,
    CMD_CLRLOCK  = 4'd8,
    CMD_TESTLOCK = 4'd9,
    CMD_SETPERM  = 4'd10,
    CMD_WAYINFO  = 4'd11
  } cmd_e;

endpackage

// File: rtl/tagdir_way_match.sv
module tagdir_way_match
  import tagdir_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16
) (
  input  logic [WAYS-1:0]                way_occ,
  input  logic [WAYS-1:0][PERM_W-1:0]    way_perm,
  input  logic [WAYS-1:0][ADDR_W-1:0]    way_tag,
  input  logic [ADDR_W-1:0]              probe_addr,
  output logic                           hit,
  output logic [WAYS-1:0]                hit_vec,
  output logic [$clog2(WAYS)-1:0]        hit_way,
  output logic                           free_any,
  output logic [$clog2(WAYS)-1:0]        free_way,
  output logic                           tag_seen
);

  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] tag_eq;
  logic [WAYS-1:0] free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_eq[w]   = way_occ[w] && (way_tag[w] == probe_addr);
    assign hit_vec[w]  = tag_eq[w] && (way_perm[w] != PERM_NOT_PRESENT);
    assign free_vec[w] = !way_occ[w] || (way_perm[w] == PERM_NOT_PRESENT);
  end

  assign hit      = |hit_vec;
  assign free_any = |free_vec;
  assign tag_seen = |tag_eq;

  // downward scan so the lowest-numbered way wins
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tagdir_lru_ranks.sv
module tagdir_lru_ranks #(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      touch_en,
  input  logic [$clog2(SETS)-1:0]   touch_set,
  input  logic [$clog2(WAYS)-1:0]   touch_way,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  output logic [$clog2(WAYS)-1:0]   victim_way
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0] oldest_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][WAY_W-1:0] rank_q;
    logic [WAYS-1:0][WAY_W-1:0] rank_d;
    logic                       set_en;

    assign set_en = touch_en && (touch_set == SET_W'(s));

    // rank 0 is most recent; younger-than-touched ways age by one
    always_comb begin
      rank_d = rank_q;
      for (int w = 0; w < WAYS; w++) begin
        if (touch_way == WAY_W'(w)) begin
          rank_d[w] = '0;
        end else if (rank_q[w] < rank_q[touch_way]) begin
          rank_d[w] = rank_q[w] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) rank_q[w] <= WAY_W'(w);
      end else if (set_en) begin
        rank_q <= rank_d;
      end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_old
      assign oldest_all[s][w] = (rank_q[w] == OLDEST);
    end

    // R8
    one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_all[s]) == 1);
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oldest_all[rd_set][w]) victim_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int IDX_LO = 2,
  parameter int CTX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [3:0]                req_cmd,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [CTX_W-1:0]          req_ctx,
  input  logic                      req_touch,
  input  logic [2:0]                req_perm,
  input  logic [$clog2(WAYS)-1:0]   req_way,
  output logic                      rsp_valid,
  output logic                      rsp_ok,
  output logic                      rsp_err,
  output logic [$clog2(WAYS)-1:0]   rsp_way,
  output logic [ADDR_W-1:0]         rsp_addr,
  output logic [2:0]                rsp_perm,
  output logic                      rsp_invalid,
  output logic                      rsp_not_busy
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  typedef struct packed {
    logic              occ;
    logic [PERM_W-1:0] perm;
    logic [CTX_W-1:0]  lock;
    logic [ADDR_W-1:0] tag;
  } entry_t;

  typedef struct packed {
    logic              valid;
    logic              ok;
    logic              err;
    logic [WAY_W-1:0]  way;
    logic [ADDR_W-1:0] addr;
    logic [PERM_W-1:0] perm;
    logic              inv;
    logic              nb;
  } rsp_t;

  localparam int ENT_W = $bits(entry_t);
  localparam logic [CTX_W-1:0] NO_OWNER = {CTX_W{1'b1}};
  localparam entry_t EMPTY_ENT = '{occ: 1'b0, perm: PERM_NOT_PRESENT,
                                   lock: {CTX_W{1'b1}}, tag: {ADDR_W{1'b0}}};

  entry_t ent_q [SETS][WAYS];
  entry_t ent_d;
  logic   ent_we;
  logic [WAY_W-1:0] ent_way;

  rsp_t rsp_q, rsp_d;

  cmd_e             cmd;
  logic [SET_W-1:0] req_set;

  logic [WAYS-1:0]              sel_occ;
  logic [WAYS-1:0][PERM_W-1:0]  sel_perm;
  logic [WAYS-1:0][ADDR_W-1:0]  sel_tag;

  logic             m_hit, m_free_any, m_tag_seen, avail;
  logic [WAYS-1:0]  m_hit_vec;
  logic [WAY_W-1:0] m_hit_way, m_free_way, lru_victim;
  logic             lru_touch;
  logic [WAY_W-1:0] lru_way;
  entry_t           hit_ent;

  assign cmd     = cmd_e'(req_cmd);
  assign req_set = req_addr[IDX_LO +: SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      sel_occ[w]  = ent_q[req_set][w].occ;
      sel_perm[w] = ent_q[req_set][w].perm;
      sel_tag[w]  = ent_q[req_set][w].tag;
    end
  end

  tagdir_way_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .way_occ    (sel_occ),
    .way_perm   (sel_perm),
    .way_tag    (sel_tag),
    .probe_addr (req_addr),
    .hit        (m_hit),
    .hit_vec    (m_hit_vec),
    .hit_way    (m_hit_way),
    .free_any   (m_free_any),
    .free_way   (m_free_way),
    .tag_seen   (m_tag_seen)
  );

  tagdir_lru_ranks #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (lru_touch),
    .touch_set  (req_set),
    .touch_way  (lru_way),
    .rd_set     (req_set),
    .victim_way (lru_victim)
  );

  assign avail   = m_free_any || m_tag_seen;
  assign hit_ent = ent_q[req_set][m_hit_way];

  // ---------------- command decode / next state ----------------
  always_comb begin
    ent_we    = 1'b0;
    ent_way   = m_hit_way;
    ent_d     = hit_ent;
    lru_touch = 1'b0;
    lru_way   = m_hit_way;
    rsp_d     = '0;
    rsp_d.valid = req_valid;
    if (req_valid) begin
      unique case (cmd)
        CMD_LOOKUP: begin
          rsp_d.ok = m_hit;
          if (m_hit) begin
            rsp_d.way  = m_hit_way;
            rsp_d.addr = hit_ent.tag;
            rsp_d.perm = hit_ent.perm;
          end
        end
        CMD_AVAIL: rsp_d.ok = avail;
        CMD_ALLOC: begin
          if (!m_hit && m_free_any) begin
            ent_we     = 1'b1;
            ent_way    = m_free_way;
            ent_d      = '{occ: 1'b1, perm: PERM_INVALID, lock: NO_OWNER, tag: req_addr};
            lru_touch  = req_touch;
            lru_way    = m_free_way;
            rsp_d.ok   = 1'b1;
            rsp_d.way  = m_free_way;
          end else begin
            rsp_d.err  = 1'b1;
          end
        end
        CMD_DEALLOC: begin
          if (m_hit) begin
            ent_we    = 1'b1;
            ent_d     = '{occ: 1'b0, perm: PERM_NOT_PRESENT, lock: NO_OWNER, tag: hit_ent.tag};
            rsp_d.ok  = 1'b1;
            rsp_d.way = m_hit_way;
          end else begin
            rsp_d.err = 1'b1;
          end
        end
        CMD_PROBE: begin
          if (!avail) begin
            rsp_d.ok   = 1'b1;
            rsp_d.way  = lru_victim;
            rsp_d.addr = ent_q[req_set][lru_victim].tag;
          end else begin
            rsp_d.err  = 1'b1;
          end
        end
        CMD_TOUCH: begin
          lru_touch = m_hit;
          rsp_d.ok  = m_hit;
          if (m_hit) rsp_d.way = m_hit_way;
        end
        CMD_SETLOCK, CMD_CLRLOCK, CMD_SETPERM: begin
          if (m_hit) begin
            ent_we    = 1'b1;
            if (cmd == CMD_SETLOCK)      ent_d.lock = req_ctx;
            else if (cmd == CMD_CLRLOCK) ent_d.lock = NO_OWNER;
            else                         ent_d.perm = req_perm;
            rsp_d.ok  = 1'b1;
            rsp_d.way = m_hit_way;
          end else begin
            rsp_d.err = 1'b1;
          end
        end
        CMD_TESTLOCK: begin
          if (m_hit) begin
            rsp_d.ok  = (hit_ent.lock == req_ctx);
            rsp_d.way = m_hit_way;
          end else begin
            rsp_d.err = 1'b1;
          end
        end
        CMD_WAYINFO: begin
          rsp_d.ok   = ent_q[req_set][req_way].occ;
          rsp_d.way  = req_way;
          rsp_d.addr = ent_q[req_set][req_way].occ ? ent_q[req_set][req_way].tag : '0;
          rsp_d.perm = ent_q[req_set][req_way].perm;
          rsp_d.inv  = (ent_q[req_set][req_way].perm == PERM_INVALID);
          rsp_d.nb   = (ent_q[req_set][req_way].perm != PERM_BUSY);
        end
        default: ;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_q[s][w] <= EMPTY_ENT;
    end else if (ent_we) begin
      ent_q[req_set][ent_way] <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= '0;
    else        rsp_q <= rsp_d;
  end

  assign rsp_valid    = rsp_q.valid;
  assign rsp_ok       = rsp_q.ok;
  assign rsp_err      = rsp_q.err;
  assign rsp_way      = rsp_q.way;
  assign rsp_addr     = rsp_q.addr;
  assign rsp_perm     = rsp_q.perm;
  assign rsp_invalid  = rsp_q.inv;
  assign rsp_not_busy = rsp_q.nb;

  // ---------------- assertions ----------------
  logic [SETS*WAYS*ENT_W-1:0] ent_flat;
  always_comb begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        ent_flat[(s*WAYS+w)*ENT_W +: ENT_W] = ent_q[s][w];
  end

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_hit_vec));

  // R4
  alloc_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && $past(req_cmd) == CMD_ALLOC) |->
      (ent_q[$past(req_set)][rsp_way].perm == PERM_INVALID &&
       ent_q[$past(req_set)][rsp_way].lock == NO_OWNER &&
       ent_q[$past(req_set)][rsp_way].occ));

  // R6
  dealloc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && $past(req_cmd) == CMD_DEALLOC) |->
      !ent_q[$past(req_set)][rsp_way].occ);

  // R11
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($stable(ent_flat) && !rsp_ok));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_ok && !rsp_err && rsp_addr == '0));

endmodule

// File: tb/tag_directory_bench.sv
module tag_directory_bench;

  localparam int ADDR_W = 16;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int IDX_LO = 2;
  localparam int CTX_W  = 4;
  localparam int NONE   = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [3:0] req_cmd;
  logic [ADDR_W-1:0] req_addr;
  logic [CTX_W-1:0] req_ctx;
  logic req_touch;
  logic [2:0] req_perm;
  logic [1:0] req_way;
  logic rsp_valid, rsp_ok, rsp_err, rsp_invalid, rsp_not_busy;
  logic [1:0] rsp_way;
  logic [ADDR_W-1:0] rsp_addr;
  logic [2:0] rsp_perm;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tag_directory #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .IDX_LO(IDX_LO), .CTX_W(CTX_W))
  u_tag_directory (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_ctx(req_ctx), .req_touch(req_touch),
    .req_perm(req_perm), .req_way(req_way), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_addr(rsp_addr),
    .rsp_perm(rsp_perm), .rsp_invalid(rsp_invalid), .rsp_not_busy(rsp_not_busy)
  );

  // behavioural model
  bit m_occ [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_perm[SETS][WAYS];
  int m_lock[SETS][WAYS];
  int m_order[SETS][$];   // front = most recent

  int e_valid, e_ok, e_err, e_way, e_addr, e_perm, e_inv, e_nb;

  function automatic void model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_order[s].delete();
      for (int w = 0; w < WAYS; w++) begin
        m_occ[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0; m_lock[s][w] = NONE;
        m_order[s].push_back(w);
      end
    end
  endfunction

  function automatic int find_hit(int s, int a);
    for (int w = 0; w < WAYS; w++)
      if (m_occ[s][w] && m_tag[s][w] == a && m_perm[s][w] != 0) return w;
    return -1;
  endfunction

  function automatic int first_free(int s);
    for (int w = 0; w < WAYS; w++)
      if (!m_occ[s][w] || m_perm[s][w] == 0) return w;
    return -1;
  endfunction

  function automatic bit is_avail(int s, int a);
    if (first_free(s) >= 0) return 1;
    for (int w = 0; w < WAYS; w++) if (m_occ[s][w] && m_tag[s][w] == a) return 1;
    return 0;
  endfunction

  function automatic void promote(int s, int w);
    for (int i = 0; i < m_order[s].size(); i++)
      if (m_order[s][i] == w) begin m_order[s].delete(i); break; end
    m_order[s].push_front(w);
  endfunction

  function automatic void model_step(int c, int a, int ctx, int tch, int pm, int wy);
    int s, h, f;
    s = (a >> IDX_LO) % SETS;
    h = find_hit(s, a);
    e_valid = 1; e_ok = 0; e_err = 0; e_way = 0; e_addr = 0; e_perm = 0; e_inv = 0; e_nb = 0;
    case (c)
      1: if (h >= 0) begin e_ok = 1; e_way = h; e_addr = a; e_perm = m_perm[s][h]; end
      2: e_ok = is_avail(s, a);
      3: begin
        f = first_free(s);
        if (h < 0 && f >= 0) begin
          m_occ[s][f] = 1; m_tag[s][f] = a; m_perm[s][f] = 1; m_lock[s][f] = NONE;
          if (tch != 0) promote(s, f);
          e_ok = 1; e_way = f;
        end else e_err = 1;
      end
      4: if (h >= 0) begin
           m_occ[s][h] = 0; m_perm[s][h] = 0; m_lock[s][h] = NONE; e_ok = 1; e_way = h;
         end else e_err = 1;
      5: if (!is_avail(s, a)) begin
           e_ok = 1; e_way = m_order[s][WAYS-1]; e_addr = m_tag[s][e_way];
         end else e_err = 1;
      6: if (h >= 0) begin promote(s, h); e_ok = 1; e_way = h; end
      7, 8, 10: if (h >= 0) begin
           if (c == 7) m_lock[s][h] = ctx;
           else if (c == 8) m_lock[s][h] = NONE;
           else m_perm[s][h] = pm;
           e_ok = 1; e_way = h;
         end else e_err = 1;
      9: if (h >= 0) begin e_ok = (m_lock[s][h] == ctx); e_way = h; end else e_err = 1;
      11: begin
        e_ok = m_occ[s][wy]; e_way = wy;
        e_addr = m_occ[s][wy] ? m_tag[s][wy] : 0;
        e_perm = m_perm[s][wy]; e_inv = (m_perm[s][wy] == 1); e_nb = (m_perm[s][wy] != 4);
      end
      default: ;
    endcase
  endfunction

  task automatic compare(input string rq);
    checks++;
    if (rsp_valid !== e_valid[0] || rsp_ok !== e_ok[0] || rsp_err !== e_err[0] ||
        int'(rsp_way) != e_way || int'(rsp_addr) != e_addr || int'(rsp_perm) != e_perm ||
        rsp_invalid !== e_inv[0] || rsp_not_busy !== e_nb[0]) begin
      failures++;
      $display("FAIL %s actual v=%0b ok=%0b err=%0b way=%0d addr=%h perm=%0d inv=%0b nb=%0b expected v=%0d ok=%0d err=%0d way=%0d addr=%h perm=%0d inv=%0d nb=%0d",
               rq, rsp_valid, rsp_ok, rsp_err, rsp_way, rsp_addr, rsp_perm, rsp_invalid, rsp_not_busy,
               e_valid, e_ok, e_err, e_way, e_addr, e_perm, e_inv, e_nb);
    end
  endtask

  task automatic run_cmd(input int c, input int a, input int ctx, input int tch,
                         input int pm, input int wy, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'(c); req_addr = ADDR_W'(a); req_ctx = CTX_W'(ctx);
    req_touch = 1'(tch); req_perm = 3'(pm); req_way = 2'(wy);
    model_step(c, a, ctx, tch, pm, wy);
    @(posedge clk); #2;
    compare(rq);
    req_valid = 1'b0; req_cmd = '0;
  endtask

  task automatic idle_check(input string rq);
    @(negedge clk);
    req_valid = 1'b0;
    e_valid = 0; e_ok = 0; e_err = 0; e_way = 0; e_addr = 0; e_perm = 0; e_inv = 0; e_nb = 0;
    @(posedge clk); #2;
    compare(rq);
  endtask

  // addresses in set 1 (bits [3:2] = 01) and set 0
  localparam int A = 16'h0004, B = 16'h0014, C = 16'h0024, D = 16'h0034, E = 16'h0044, F = 16'h0054;
  localparam int Z = 16'h0100;

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_ctx = '0;
    req_touch = 1'b0; req_perm = '0; req_way = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle_check("R12 reset");
    run_cmd(11, A, 0, 0, 0, 2, "R12 empty way after reset");

    run_cmd(1, A, 0, 0, 0, 0, "R2 miss on empty");
    run_cmd(2, A, 0, 0, 0, 0, "R3 empty set available");
    run_cmd(3, A, 0, 0, 0, 0, "R4 alloc way0");
    run_cmd(1, A, 0, 0, 0, 0, "R2 hit Invalid");
    run_cmd(11, A, 0, 0, 0, 0, "R10 way info Invalid");
    run_cmd(9, A, NONE, 0, 0, 0, "R4 alloc leaves no owner");
    run_cmd(3, A, 0, 1, 0, 0, "R4 alloc present refused");
    run_cmd(3, B, 0, 1, 0, 0, "R5 alloc touch");
    run_cmd(3, C, 0, 1, 0, 0, "R5 alloc touch");
    run_cmd(3, D, 0, 1, 0, 0, "R5 alloc touch");
    run_cmd(2, E, 0, 0, 0, 0, "R3 full set unavailable");
    run_cmd(2, A, 0, 0, 0, 0, "R3 present address available");
    run_cmd(3, E, 0, 0, 0, 0, "R4 alloc full refused");
    run_cmd(5, E, 0, 0, 0, 0, "R7 probe victim untouched way0");
    run_cmd(6, A, 0, 0, 0, 0, "R8 touch A");
    run_cmd(5, E, 0, 0, 0, 0, "R7 probe after touch");
    run_cmd(5, A, 0, 0, 0, 0, "R7 probe with avail refused");
    run_cmd(6, F, 0, 0, 0, 0, "R8 touch miss no-op");
    run_cmd(1, Z, 0, 0, 0, 0, "R1 other set empty");
    run_cmd(3, Z, 0, 0, 0, 0, "R1 other set alloc way0");
    run_cmd(10, B, 0, 0, 4, 0, "R10 set Busy");
    run_cmd(11, B, 0, 0, 0, 1, "R10 way info Busy");
    run_cmd(10, C, 0, 0, 0, 0, "R10 set NotPresent");
    run_cmd(1, C, 0, 0, 0, 0, "R2 NotPresent misses");
    run_cmd(2, E, 0, 0, 0, 0, "R3 NotPresent way free");
    run_cmd(3, E, 0, 0, 0, 0, "R4 reuse NotPresent way");
    run_cmd(1, E, 0, 0, 0, 0, "R2 hit reused way");
    run_cmd(9, A, 3, 0, 0, 0, "R9 no owner test");
    run_cmd(7, A, 3, 0, 0, 0, "R9 set lock");
    run_cmd(9, A, 3, 0, 0, 0, "R9 owner match");
    run_cmd(9, A, 5, 0, 0, 0, "R9 owner mismatch");
    run_cmd(8, A, 0, 0, 0, 0, "R9 clear lock");
    run_cmd(9, A, 3, 0, 0, 0, "R9 cleared");
    run_cmd(7, F, 2, 0, 0, 0, "R9 lock absent refused");
    run_cmd(1, F, 0, 0, 0, 0, "R11 refused left no line");
    run_cmd(7, D, 7, 0, 0, 0, "R9 lock D");
    run_cmd(4, D, 0, 0, 0, 0, "R6 dealloc D");
    run_cmd(1, D, 0, 0, 0, 0, "R6 dealloc then miss");
    run_cmd(3, D, 0, 0, 0, 0, "R4 realloc D");
    run_cmd(9, D, 7, 0, 0, 0, "R4 old owner gone");
    run_cmd(4, F, 0, 0, 0, 0, "R6 dealloc absent refused");
    run_cmd(12, A, 0, 0, 0, 0, "R12 unused code quiet");
    idle_check("R12 idle");

    for (int i = 0; i < 600; i++) begin
      int c, a;
      c = $urandom_range(1, 11);
      a = ($urandom_range(0, 5) << 4) | ($urandom_range(0, 3) << IDX_LO);
      run_cmd(c, a, $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 4),
              $urandom_range(0, 3), "R11 mixed sequence");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule